// File: doc/BRIEF.md
# Interrupt Redirection Controller with Message Output

This block turns pin service requests into message-signalled interrupts. Software sets it up through two memory-mapped registers. A select register holds an internal index, and a window register reads or writes whichever internal register that index names. Each input pin owns one 64-bit redirection entry. The entry is reached through two consecutive 32-bit indices. It carries the pin's vector, its destination and a mask bit.

A service request names a pin. If that pin's entry is unmasked, the request is latched in a per-pin pending bit. Whenever the output slot is free, the lowest-numbered pending pin is granted. Its entry is formatted into an address/data write and offered on a valid/ready port. The port holds the message unchanged until it is accepted. Only physical destinations and edge-triggered delivery are modelled.

Top module: `msi_redirector`

## Requirements
- R1: A write to byte offset 0x00 stores bits [7:0] of the write data as the select index, and a read of offset 0x00 returns that index zero-extended. Read data appears on `rdata` in the cycle after `rd_en`.
- R2: For pin p below 24, index 0x10+2p reaches bits [31:0] of entry p and index 0x11+2p reaches bits [63:32]. A full 64-bit value written as two halves through the window at offset 0x10 reads back unchanged.
- R3: Window reads at an index outside 0x10..0x3F return zero, and window writes there change no entry. Reads of any offset other than 0x00 and 0x10 return zero, and writes to those offsets change nothing.
- R4: After reset every entry reads 0x00000000_00010000 (mask set), the select index is 0 and `msi_valid` is low.
- R5: The message for pin p has address 0xFEE00000 | (entry[63:56] << 12) and data equal to entry[7:0] zero-extended. For example, vector 0x24 with destination 2 gives 0xFEE02000 / 0x24.
- R6: Entry bit 16 is the mask. A request for a masked pin produces no message, and a pending request whose pin becomes masked before it is granted is dropped.
- R7: A service request with a pin number of 24 or more produces no message.
- R8: While `msi_valid` is high and `msi_ready` is low, `msi_valid`, `msi_addr` and `msi_data` stay unchanged. `msi_valid` falls only after a cycle in which `msi_ready` was high.
- R9: Requests arriving while a message is outstanding are kept as pending bits. Pending pins are delivered lowest number first. Repeated requests for one pin that is already pending yield a single message.
- R10: With the output idle, a request sampled at edge N gives `msi_valid` high after edge N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| svc_valid | input | 1 | Pin service request strobe |
| svc_pin | input | 8 | Pin number being serviced |
| msi_valid | output | 1 | Message offered |
| msi_ready | input | 1 | Message accepted when high with msi_valid |
| msi_addr | output | 32 | Message write address |
| msi_data | output | 32 | Message write data |

## Verification
The checker watches the output handshake on every cycle. It checks that a stalled message keeps its address and data and that valid drops only after acceptance. It also checks the fixed address pattern and the zero upper data bits, that the output is idle just after reset, and that out-of-range window reads return zero. Which pin is granted first, the merging of repeated requests, mask handling at request and at grant time, and the exact readback of programmed entries depend on sequences of accesses. Only the bench's directed and random scenarios against its shadow table can show those.

// File: rtl/msi_redir_pkg.sv
package msi_redir_pkg;

    localparam logic [31:0] MSI_BASE   = 32'hFEE0_0000;
    localparam int          DEST_SHIFT = 12;
    localparam logic [7:0]  TBL_BASE   = 8'h10;
    localparam logic [7:0]  OFS_SELECT = 8'h00;
    localparam logic [7:0]  OFS_WINDOW = 8'h10;

    localparam int VEC_LSB  = 0;
    localparam int MASK_BIT = 16;
    localparam int DEST_LSB = 56;

    localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } msi_msg_t;

    function automatic msi_msg_t format_msg(logic [63:0] entry);
        msi_msg_t m;
        m.addr = MSI_BASE | ({24'd0, entry[DEST_LSB +: 8]} << DEST_SHIFT);
        m.data = {24'd0, entry[VEC_LSB +: 8]};
        return m;
    endfunction

endpackage

// File: rtl/msi_redir_regwin.sv
module msi_redir_regwin
    import msi_redir_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 8,
    parameter int PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic [IDX_W-1:0] sel_q,
    output logic             ent_wr,
    output logic             ent_hi,
    output logic [PIN_W-1:0] ent_pin,
    input  logic [63:0]      ent_rd
);
    localparam logic [IDX_W-1:0] BASE_I = IDX_W'(TBL_BASE);
    localparam logic [IDX_W-1:0] END_I  = IDX_W'(int'(TBL_BASE) + 2 * NPINS);

    logic [IDX_W-1:0] rel;
    logic             in_range;
    logic [31:0]      rd_val;

    assign rel      = sel_q - BASE_I;
    assign in_range = (sel_q >= BASE_I) && (sel_q < END_I);
    assign ent_pin  = rel[PIN_W:1];
    assign ent_hi   = rel[0];
    assign ent_wr   = wr_en && (addr == OFS_WINDOW) && in_range;

    always_comb begin
        rd_val = '0;
        if (addr == OFS_SELECT)
            rd_val = 32'(sel_q);
        else if (addr == OFS_WINDOW && in_range)
            rd_val = ent_hi ? ent_rd[63:32] : ent_rd[31:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            rdata <= '0;
        end else begin
            if (wr_en && addr == OFS_SELECT)
                sel_q <= wdata[IDX_W-1:0];
            if (rd_en)
                rdata <= rd_val;
        end
    end
endmodule

// File: rtl/msi_redir_table.sv
module msi_redir_table
    import msi_redir_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             wr_hi,
    input  logic [PIN_W-1:0] wr_pin,
    input  logic [31:0]      wdata,
    input  logic [PIN_W-1:0] rd_pin,
    output logic [63:0]      rd_entry,
    input  logic [PIN_W-1:0] gnt_pin,
    output logic [63:0]      gnt_entry,
    output logic [NPINS-1:0] mask
);
    logic [63:0] ent_q [NPINS];

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent_q[g] <= ENTRY_RESET;
            else if (wr && wr_pin == PIN_W'(g)) begin
                if (wr_hi) ent_q[g][63:32] <= wdata;
                else       ent_q[g][31:0]  <= wdata;
            end
        end
        assign mask[g] = ent_q[g][MASK_BIT];
    end

    assign rd_entry  = (rd_pin  < PIN_W'(NPINS)) ? ent_q[rd_pin]  : '0;
    assign gnt_entry = (gnt_pin < PIN_W'(NPINS)) ? ent_q[gnt_pin] : '0;
endmodule

// File: rtl/msi_redir_dispatch.sv
module msi_redir_dispatch
    import msi_redir_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = 5,
    parameter int SVC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             svc_valid,
    input  logic [SVC_W-1:0] svc_pin,
    input  logic [NPINS-1:0] mask,
    output logic [PIN_W-1:0] gnt_pin,
    input  logic [63:0]      gnt_entry,
    output logic             msi_valid,
    input  logic             msi_ready,
    output msi_msg_t         msg
);
    logic [NPINS-1:0] pend_q, pend_d, req_oh, cand, gnt_oh;
    logic             found, load;

    always_comb begin
        req_oh = '0;
        if (svc_valid && svc_pin < SVC_W'(NPINS))
            req_oh[svc_pin[PIN_W-1:0]] = 1'b1;

        cand    = pend_q & ~mask;
        found   = 1'b0;
        gnt_pin = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found   = 1'b1;
                gnt_pin = PIN_W'(i);
            end
        end

        load   = found && (!msi_valid || msi_ready);
        gnt_oh = load ? (NPINS'(1) << gnt_pin) : '0;
        pend_d = ((pend_q & ~gnt_oh) | req_oh) & ~mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            msi_valid <= 1'b0;
            msg       <= '0;
        end else begin
            pend_q <= pend_d;
            if (load) begin
                msi_valid <= 1'b1;
                msg       <= format_msg(gnt_entry);
            end else if (msi_ready) begin
                msi_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/msi_redirector.sv
module msi_redirector
    import msi_redir_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 8,
    parameter int SVC_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        svc_valid,
    input  logic [7:0]  svc_pin,
    output logic        msi_valid,
    input  logic        msi_ready,
    output logic [31:0] msi_addr,
    output logic [31:0] msi_data
);
    localparam int PIN_W = $clog2(NPINS);

    logic [IDX_W-1:0] sel_q;
    logic             ent_wr, ent_hi;
    logic [PIN_W-1:0] ent_pin, gnt_pin;
    logic [63:0]      ent_rd, gnt_entry;
    logic [NPINS-1:0] mask;
    msi_msg_t         msg;

    msi_redir_regwin #(.NPINS(NPINS), .IDX_W(IDX_W), .PIN_W(PIN_W)) u_win (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sel_q(sel_q), .ent_wr(ent_wr),
        .ent_hi(ent_hi), .ent_pin(ent_pin), .ent_rd(ent_rd)
    );

    msi_redir_table #(.NPINS(NPINS), .PIN_W(PIN_W)) u_tbl (
        .clk(clk), .rst(rst), .wr(ent_wr), .wr_hi(ent_hi), .wr_pin(ent_pin),
        .wdata(wdata), .rd_pin(ent_pin), .rd_entry(ent_rd),
        .gnt_pin(gnt_pin), .gnt_entry(gnt_entry), .mask(mask)
    );

    msi_redir_dispatch #(.NPINS(NPINS), .PIN_W(PIN_W), .SVC_W(SVC_W)) u_dsp (
        .clk(clk), .rst(rst), .svc_valid(svc_valid), .svc_pin(SVC_W'(svc_pin)),
        .mask(mask), .gnt_pin(gnt_pin), .gnt_entry(gnt_entry),
        .msi_valid(msi_valid), .msi_ready(msi_ready), .msg(msg)
    );

    assign msi_addr = msg.addr;
    assign msi_data = msg.data;
endmodule

// File: rtl/msi_redir_chk.sv
module msi_redir_chk #(
    parameter int NPINS = 24
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic [7:0]  addr,
    input logic [7:0]  sel_idx,
    input logic [31:0] rdata,
    input logic        msi_valid,
    input logic        msi_ready,
    input logic [31:0] msi_addr,
    input logic [31:0] msi_data
);
    localparam int TOP_IDX = 16 + 2 * NPINS;

    // R8: a stalled message keeps its contents
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        msi_valid && !msi_ready |=> msi_valid && $stable(msi_addr) && $stable(msi_data));

    // R8: valid drops only after acceptance
    assert_drop_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(msi_valid) |-> $past(msi_ready));

    // R5: address and data layout of an offered message
    assert_msg_format_R5: assert property (@(posedge clk) disable iff (rst)
        msi_valid |-> (msi_addr[31:20] == 12'hFEE) && (msi_addr[11:0] == 12'h000)
                      && (msi_data[31:8] == 24'd0));

    // R4: the output is idle right after reset
    assert_idle_after_reset_R4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !msi_valid);

    // R3: window reads outside the table return zero
    assert_oob_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == 8'h10 && (int'(sel_idx) < 16 || int'(sel_idx) >= TOP_IDX)
        |=> rdata == 32'd0);
endmodule

bind msi_redirector msi_redir_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .sel_idx(8'(sel_q)),
    .rdata(rdata), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data)
);

// File: tb/msi_redirector_test.sv
`timescale 1ns/1ps
module msi_redirector_test;
    logic        clk = 0, rst = 1;
    logic        wr_en = 0, rd_en = 0, svc_valid = 0, msi_ready = 0;
    logic [7:0]  addr = 0, svc_pin = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata, msi_addr, msi_data;
    logic        msi_valid;

    int nvec = 0, nerr = 0;
    bit done = 0;
    logic [63:0] mtbl [24];

    always #2.5 clk = ~clk;

    msi_redirector uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .svc_valid(svc_valid), .svc_pin(svc_pin),
        .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
        .msi_data(msi_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_win(input int idx);
        if (idx < 16 || idx >= 16 + 48) return 32'd0;
        return ((idx - 16) % 2) ? mtbl[(idx - 16) / 2][63:32] : mtbl[(idx - 16) / 2][31:0];
    endfunction

    function automatic logic [31:0] exp_addr(input logic [63:0] e);
        return 32'hFEE0_0000 | (32'(e[63:56]) << 12);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 0; d = rdata;
    endtask

    task automatic prog(input int pin, input logic [63:0] e);
        wr(8'h00, 32'(16 + 2 * pin)); wr(8'h10, e[31:0]);
        wr(8'h00, 32'(17 + 2 * pin)); wr(8'h10, e[63:32]);
        mtbl[pin] = e;
    endtask

    task automatic svc(input logic [7:0] p);
        svc_valid = 1; svc_pin = p;
        @(posedge clk); @(negedge clk);
        svc_valid = 0;
    endtask

    task automatic take(output bit found, output logic [31:0] a, output logic [31:0] d);
        found = 0; a = 0; d = 0;
        for (int i = 0; i < 8 && !found; i++) begin
            if (msi_valid) begin
                found = 1; a = msi_addr; d = msi_data;
                msi_ready = 1;
                @(posedge clk); @(negedge clk);
                msi_ready = 0;
            end else begin
                @(posedge clk); @(negedge clk);
            end
        end
    endtask

    function automatic logic [63:0] mk(input logic [7:0] vec, input logic [7:0] dst, input bit m);
        return {dst, 24'd0, 15'd0, m, 8'd0, vec};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, a, d;
        bit f;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 24; i++) mtbl[i] = 64'h0000_0000_0001_0000;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R4: reset state
        check("R4 msi_valid", 64'(msi_valid), 64'd0);
        rd(8'h00, r); check("R4 select", 64'(r), 64'd0);
        wr(8'h00, 32'h16); rd(8'h10, r); check("R4 entry lo", 64'(r), 64'h0001_0000);
        wr(8'h00, 32'h17); rd(8'h10, r); check("R4 entry hi", 64'(r), 64'd0);

        // R1 and R2: full-entry round trip
        wr(8'h00, 32'hA5); rd(8'h00, r); check("R1 select readback", 64'(r), 64'hA5);
        prog(0, 64'hABCDEF00_12345678);
        wr(8'h00, 32'h10); rd(8'h10, r); check("R2 lo", 64'(r), 64'h12345678);
        wr(8'h00, 32'h11); rd(8'h10, r); check("R2 hi", 64'(r), 64'hABCDEF00);

        // R3: window at indices just outside the table, and stray offsets
        wr(8'h00, 32'h40); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, r); check("R3 idx 0x40", 64'(r), 64'd0);
        wr(8'h00, 32'h0F); rd(8'h10, r); check("R3 idx 0x0F", 64'(r), 64'd0);
        wr(8'h00, 32'h3F); rd(8'h10, r); check("R3 last idx intact", 64'(r), 64'(mtbl[23][63:32]));
        wr(8'h08, 32'h77); rd(8'h08, r); check("R3 stray offset", 64'(r), 64'd0);
        rd(8'h00, r); check("R3 select untouched", 64'(r), 64'h3F);

        // R1, R2, R3: random window traffic against the shadow table
        for (int i = 0; i < 300; i++) begin
            int idx;
            idx = $urandom_range(0, 8'h4F);
            wr(8'h00, 32'(idx));
            if ($urandom_range(0, 1)) begin
                logic [31:0] v;
                v = $urandom();
                wr(8'h10, v);
                if (idx >= 16 && idx < 64) begin
                    if ((idx - 16) % 2) mtbl[(idx - 16) / 2][63:32] = v;
                    else                mtbl[(idx - 16) / 2][31:0]  = v;
                end
            end else begin
                rd(8'h10, r); check("R2/R3 random window read", 64'(r), 64'(model_win(idx)));
            end
        end

        // R5, R10: directed message with latency check
        prog(4, mk(8'h24, 8'h02, 0));
        svc_valid = 1; svc_pin = 8'd4;
        @(posedge clk); @(negedge clk); svc_valid = 0;
        check("R10 not yet valid", 64'(msi_valid), 64'd0);
        @(posedge clk); @(negedge clk);
        check("R10 valid after two edges", 64'(msi_valid), 64'd1);
        take(f, a, d);
        check("R5 addr", 64'(a), 64'hFEE02000);
        check("R5 data", 64'(d), 64'h24);

        // R6: masked pin, R7: pin out of range
        prog(6, mk(8'h66, 8'h01, 1));
        svc(8'd6); take(f, a, d); check("R6 masked no msg", 64'(f), 64'd0);
        svc(8'd24); take(f, a, d); check("R7 pin 24 no msg", 64'(f), 64'd0);
        svc(8'd200); take(f, a, d); check("R7 pin 200 no msg", 64'(f), 64'd0);

        // R8, R9: stall, queueing, lowest first, merge, masked-while-pending
        prog(3, mk(8'h33, 8'h03, 0));
        prog(5, mk(8'h55, 8'h05, 0));
        prog(7, mk(8'h77, 8'h07, 0));
        prog(9, mk(8'h99, 8'h09, 0));
        svc(8'd7);
        @(posedge clk); @(negedge clk);
        svc(8'd5); svc(8'd3); svc(8'd3); svc(8'd9);
        prog(9, mk(8'h99, 8'h09, 1));
        check("R8 held valid", 64'(msi_valid), 64'd1);
        check("R8 held addr", 64'(msi_addr), 64'hFEE07000);
        check("R8 held data", 64'(msi_data), 64'h77);
        take(f, a, d); check("R9 first pin 7", 64'(d), 64'h77);
        take(f, a, d); check("R9 second pin 3", 64'(d), 64'h33);
        take(f, a, d); check("R9 third pin 5", 64'(d), 64'h55);
        take(f, a, d); check("R9 merged, R6 dropped pin 9", 64'(f), 64'd0);

        // R5, R6, R7: random single requests
        for (int i = 0; i < 60; i++) begin
            int p;
            logic [63:0] e;
            p = $urandom_range(0, 31);
            if (p < 24 && $urandom_range(0, 1)) begin
                e = mk(8'($urandom()), 8'($urandom()), bit'($urandom_range(0, 2) == 0));
                prog(p, e);
            end
            svc(8'(p));
            take(f, a, d);
            if (p >= 24 || mtbl[p][16]) begin
                check("R6/R7 random no msg", 64'(f), 64'd0);
            end else begin
                check("R5 random addr", 64'(a), 64'(exp_addr(mtbl[p])));
                check("R5 random data", 64'(d), 64'(mtbl[p][7:0]));
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule